// File: doc/BRIEF.md
# Manchester Framed Serial Transmitter

This block serializes one character at a time onto a single line using Manchester coding. Before each character it can send a run of preamble bits in one of four patterns. It then sends a start marker. The marker is either a single coded zero bit, or a three-bit-time sync shape that breaks the Manchester rules on purpose. A receiver can therefore tell the marker apart from data. The sync shape comes in two kinds, command and data. The kind is taken from a global mode input, or, when per-character selection is on, from a flag that travels with each character.

The host offers characters through a valid/ready handshake. The block accepts a character only when it is idle. On acceptance it captures the character, its flag and every configuration input. Timing is set by a half-bit strobe. Every half of a bit time lasts exactly one strobe period. The first half starts at the first strobe after acceptance. Between characters the line rests high.

The controller is a state machine with six states:
- IDLE: the line is high and ready is asserted. An accepted character moves the block to LOAD.
- LOAD: the line stays high until the next strobe. That strobe moves the block to PRE when the preamble length is non-zero. Otherwise it moves to DELIM (one-bit marker) or SYNC (three-bit marker).
- PRE: after its last half it moves to DELIM or SYNC.
- DELIM and SYNC: after their last half they move to DATA.
- DATA: after the final half of the last bit the block returns to IDLE.

Top module: `manchester_framer_tx`

## Requirements
- R1: After reset, and whenever no character is in flight, `tx_line` is 1 and `in_ready` is 1.
- R2: A character is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then drops on the next cycle and stays low until the character ends. `tx_line` stays 1 until the first `half_tick` after acceptance.
- R3: The preamble is `cfg_pre_len` bit times long (0 to 15). A length of 0 sends no preamble, and the start marker follows at once.
- R4: Preamble bit i is coded by `cfg_pre_kind`: 0 gives all ones, 1 gives all zeros, 2 gives i mod 2 (starting with zero), and 3 gives the inverse of i mod 2 (starting with one).
- R5: Every coded bit occupies two halves, each exactly one `half_tick` period long, with a transition at mid-bit. A zero is sent low then high, and a one high then low.
- R6: With `cfg_invert` = 1, every coded symbol (preamble, one-bit marker, data) has its two halves swapped. The sync shapes are not affected.
- R7: With `cfg_sync_en` = 0, the start marker is one coded zero bit.
- R8: With `cfg_sync_en` = 1, the start marker lasts three bit times. The command sync is high for three halves, then low for three. The data sync is low for three halves, then high for three. The only transition is at the middle of the second bit time.
- R9: With `cfg_var_sync` = 0, `cfg_cmd_mode` = 1 selects command sync and 0 selects data sync. `in_cmd` has no effect.
- R10: With `cfg_var_sync` = 1, the character's own `in_cmd` (1 = command, 0 = data) selects the sync kind. `cfg_cmd_mode` has no effect.
- R11: Data bits are sent least significant bit first. Their count is `cfg_char_len`, with values below 5 treated as 5 and values above 9 treated as 9.
- R12: Configuration inputs, `in_data` and `in_cmd` are sampled only at acceptance. Changes while a character is in flight do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-bit strobe, one cycle wide |
| cfg_pre_kind | input | 2 | Preamble pattern code |
| cfg_pre_len | input | PRE_W (4) | Preamble length in bit times |
| cfg_sync_en | input | 1 | 1 selects the three-bit sync marker, 0 the one-bit marker |
| cfg_cmd_mode | input | 1 | Global sync kind, 1 = command |
| cfg_var_sync | input | 1 | 1 takes the sync kind from `in_cmd` |
| cfg_invert | input | 1 | Swaps the halves of coded symbols |
| cfg_char_len | input | LEN_W (4) | Data bits per character |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle and able to take a character |
| in_data | input | MAX_BITS (9) | Character bits, LSB sent first |
| in_cmd | input | 1 | Per-character sync kind, 1 = command |
| tx_line | output | 1 | Serial output |

## Verification
The bench builds the block with its default parameters: 9-bit maximum and 5-bit minimum character length, and a 4-bit preamble length field. With these defaults the longest preamble (15 bit times) and both clamp limits of the character length can be reached directly. The strobe period is changed between runs (every cycle, every third cycle, every fourth cycle). This shows that the half length follows the strobe and not the clock. It also covers the case where the strobe lands on the same edge as acceptance.

// File: rtl/mft_pkg.sv
package mft_pkg;

    // Controller states, in the order a character passes through them
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PRE,
        ST_DELIM,
        ST_SYNC,
        ST_DATA
    } tx_state_e;

    // Preamble pattern codes
    typedef enum logic [1:0] {
        PRE_ONES  = 2'd0,
        PRE_ZEROS = 2'd1,
        PRE_ALT0  = 2'd2,
        PRE_ALT1  = 2'd3
    } pre_kind_e;

endpackage

// File: rtl/mft_pre_pattern.sv
module mft_pre_pattern
    import mft_pkg::*;
(
    input  pre_kind_e kind,
    input  logic      idx_odd,
    output logic      pbit
);

    always_comb begin
        unique case (kind)
            PRE_ONES:  pbit = 1'b1;
            PRE_ZEROS: pbit = 1'b0;
            PRE_ALT0:  pbit = idx_odd;
            PRE_ALT1:  pbit = ~idx_odd;
        endcase
    end

endmodule

// File: rtl/mft_manch_enc.sv
module mft_manch_enc (
    input  logic sym,
    input  logic second_half,
    input  logic invert,
    output logic level
);

    // first half carries the symbol value, second half its complement
    always_comb begin
        level = sym ^ second_half ^ invert;
    end

endmodule

// File: rtl/manchester_framer_tx.sv
module manchester_framer_tx
    import mft_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int MIN_BITS = 5,
    parameter int PRE_W    = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   half_tick,
    input  logic [1:0]                             cfg_pre_kind,
    input  logic [PRE_W-1:0]                       cfg_pre_len,
    input  logic                                   cfg_sync_en,
    input  logic                                   cfg_cmd_mode,
    input  logic                                   cfg_var_sync,
    input  logic                                   cfg_invert,
    input  logic [$clog2(MAX_BITS+1)-1:0]          cfg_char_len,
    input  logic                                   in_valid,
    output logic                                   in_ready,
    input  logic [MAX_BITS-1:0]                    in_data,
    input  logic                                   in_cmd,
    output logic                                   tx_line
);

    localparam int LEN_W   = $clog2(MAX_BITS + 1);
    localparam int PRE_MAX = (1 << PRE_W) - 1;
    localparam int SEG_MAX = (PRE_MAX > MAX_BITS) ? PRE_MAX : MAX_BITS;
    localparam int CNT_W   = $clog2(2 * SEG_MAX);
    localparam int SYNC_HALVES = 6;

    tx_state_e             state_q, state_d, delim_st, next_seg;
    logic [CNT_W-1:0]      hcnt_q, hcnt_d, seg_last;
    logic [MAX_BITS-1:0]   data_q, data_shift;
    logic                  cmd_q, sync_en_q, inv_q;
    pre_kind_e             kind_q;
    logic [PRE_W-1:0]      pre_len_q;
    logic [LEN_W-1:0]      len_q, len_clamped;
    logic                  accept;
    logic                  pre_bit, sym, enc_level;
    logic [CNT_W-2:0]      bit_idx;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign delim_st = sync_en_q ? ST_SYNC : ST_DELIM;
    assign bit_idx  = hcnt_q[CNT_W-1:1];

    always_comb begin
        if (cfg_char_len < LEN_W'(MIN_BITS))
            len_clamped = LEN_W'(MIN_BITS);
        else if (cfg_char_len > LEN_W'(MAX_BITS))
            len_clamped = LEN_W'(MAX_BITS);
        else
            len_clamped = cfg_char_len;
    end

    // Segment length and successor
    always_comb begin
        seg_last = '0;
        next_seg = ST_IDLE;
        unique case (state_q)
            ST_PRE: begin
                seg_last = CNT_W'({pre_len_q, 1'b0}) - CNT_W'(1);
                next_seg = delim_st;
            end
            ST_DELIM: begin
                seg_last = CNT_W'(1);
                next_seg = ST_DATA;
            end
            ST_SYNC: begin
                seg_last = CNT_W'(SYNC_HALVES - 1);
                next_seg = ST_DATA;
            end
            ST_DATA: begin
                seg_last = CNT_W'({len_q, 1'b0}) - CNT_W'(1);
                next_seg = ST_IDLE;
            end
            default: begin
                seg_last = '0;
                next_seg = ST_IDLE;
            end
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (half_tick) begin
                    state_d = (pre_len_q != '0) ? ST_PRE : delim_st;
                    hcnt_d  = '0;
                end
            end
            default: begin
                if (half_tick) begin
                    if (hcnt_q == seg_last) begin
                        state_d = next_seg;
                        hcnt_d  = '0;
                    end else begin
                        hcnt_d = hcnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    // State register and per-character capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hcnt_q    <= '0;
            data_q    <= '0;
            cmd_q     <= 1'b0;
            kind_q    <= PRE_ONES;
            pre_len_q <= '0;
            sync_en_q <= 1'b0;
            inv_q     <= 1'b0;
            len_q     <= LEN_W'(MIN_BITS);
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
            if (accept) begin
                data_q    <= in_data;
                cmd_q     <= cfg_var_sync ? in_cmd : cfg_cmd_mode;
                kind_q    <= pre_kind_e'(cfg_pre_kind);
                pre_len_q <= cfg_pre_len;
                sync_en_q <= cfg_sync_en;
                inv_q     <= cfg_invert;
                len_q     <= len_clamped;
            end
        end
    end

    mft_pre_pattern u_pre (
        .kind    (kind_q),
        .idx_odd (bit_idx[0]),
        .pbit    (pre_bit)
    );

    assign data_shift = data_q >> bit_idx;

    mft_manch_enc u_enc (
        .sym         (sym),
        .second_half (hcnt_q[0]),
        .invert      (inv_q),
        .level       (enc_level)
    );

    // Output logic
    always_comb begin
        sym     = 1'b0;
        tx_line = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_LOAD: tx_line = 1'b1;
            ST_PRE: begin
                sym     = pre_bit;
                tx_line = enc_level;
            end
            ST_DELIM: begin
                sym     = 1'b0;
                tx_line = enc_level;
            end
            ST_SYNC: tx_line = (hcnt_q < CNT_W'(3)) ? cmd_q : ~cmd_q;
            ST_DATA: begin
                sym     = data_shift[0];
                tx_line = enc_level;
            end
            default: tx_line = 1'b1;
        endcase
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(tx_line));

    // R5
    data_midbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !hcnt_q[0] && half_tick) |=> (tx_line != $past(tx_line)));

    // R8
    sync_centre_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && hcnt_q == CNT_W'(2) && half_tick) |=> (tx_line != $past(tx_line)));

    // R8
    sync_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && hcnt_q != CNT_W'(2) && hcnt_q != CNT_W'(5) && half_tick)
            |=> $stable(tx_line));

endmodule

// File: tb/test_manchester_framer_tx.sv
module test_manchester_framer_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       half_tick;
    logic [1:0] cfg_pre_kind;
    logic [3:0] cfg_pre_len;
    logic       cfg_sync_en, cfg_cmd_mode, cfg_var_sync, cfg_invert;
    logic [3:0] cfg_char_len;
    logic       in_valid;
    logic       in_ready;
    logic [8:0] in_data;
    logic       in_cmd;
    logic       tx_line;

    always #4 clk = ~clk;

    manchester_framer_tx i_manchester_framer_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_tick    (half_tick),
        .cfg_pre_kind (cfg_pre_kind),
        .cfg_pre_len  (cfg_pre_len),
        .cfg_sync_en  (cfg_sync_en),
        .cfg_cmd_mode (cfg_cmd_mode),
        .cfg_var_sync (cfg_var_sync),
        .cfg_invert   (cfg_invert),
        .cfg_char_len (cfg_char_len),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_cmd       (in_cmd),
        .tx_line      (tx_line)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int tick_period = 3;
    int tick_cnt = 0;
    int force_tag = 0;
    bit done = 0;

    // reference model state
    bit q_lvl[$];
    int q_req[$];
    bit m_pending, m_active, m_cur, m_took;
    int m_cur_req;

    function automatic void push_half(bit lvl, int req);
        q_lvl.push_back(lvl);
        q_req.push_back(force_tag != 0 ? force_tag : req);
    endfunction

    function automatic void build(logic [8:0] d, logic c);
        int  plen = int'(cfg_pre_len);
        int  n    = (cfg_char_len < 5) ? 5 : ((cfg_char_len > 9) ? 9 : int'(cfg_char_len));
        bit  inv  = cfg_invert;
        bit  kind_cmd = cfg_var_sync ? c : cfg_cmd_mode;
        int  sync_tag = cfg_var_sync ? 10 : ((c != cfg_cmd_mode) ? 9 : 8);
        for (int i = 0; i < plen; i++) begin
            bit b;
            case (cfg_pre_kind)
                2'd0: b = 1'b1;
                2'd1: b = 1'b0;
                2'd2: b = (i % 2 == 1);
                default: b = (i % 2 == 0);
            endcase
            // R3 / R4 / R6 preamble halves
            push_half(b ^ inv, inv ? 6 : (cfg_pre_kind == 2'd0 ? 3 : 4));
            push_half(!(b ^ inv), inv ? 6 : 4);
        end
        if (!cfg_sync_en) begin
            // R7 one-bit marker: coded zero
            push_half(inv, inv ? 6 : 7);
            push_half(!inv, inv ? 6 : 7);
        end else begin
            // R8 / R9 / R10 sync shape
            for (int k = 0; k < 6; k++) push_half((k < 3) ? kind_cmd : !kind_cmd, sync_tag);
        end
        for (int i = 0; i < n; i++) begin
            // R11 LSB first, R5 half order
            push_half(d[i] ^ inv, inv ? 6 : 11);
            push_half(!(d[i] ^ inv), inv ? 6 : 5);
        end
    endfunction

    always @(posedge clk) begin
        bit rdy;
        m_took = 1'b0;
        if (!rst_n) begin
            q_lvl.delete();
            q_req.delete();
            m_pending = 0;
            m_active  = 0;
            m_cur     = 1;
            m_cur_req = 1;
        end else begin
            rdy = !(m_pending || m_active);
            if (m_pending && half_tick) begin
                m_pending = 0;
                m_active  = 1;
                m_cur     = q_lvl.pop_front();
                m_cur_req = q_req.pop_front();
            end else if (m_active && half_tick) begin
                if (q_lvl.size() == 0) begin
                    m_active = 0;
                end else begin
                    m_cur     = q_lvl.pop_front();
                    m_cur_req = q_req.pop_front();
                end
            end
            if (rdy && in_valid) begin
                build(in_data, in_cmd);
                m_pending = 1;
                m_took    = 1;
            end
        end
    end

    // strobe generator
    always @(negedge clk) begin
        if (tick_cnt >= tick_period - 1) begin
            tick_cnt  = 0;
            half_tick = 1'b1;
        end else begin
            tick_cnt++;
            half_tick = 1'b0;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            bit exp_line, exp_rdy;
            int req;
            exp_line = m_active ? m_cur : 1'b1;
            req      = m_active ? m_cur_req : (m_pending ? 2 : 1);
            exp_rdy  = !(m_pending || m_active);
            checks++;
            if (tx_line !== exp_line) begin
                errors++;
                $display("FAIL R%0d tx_line actual=%b expected=%b at cycle %0d", req, tx_line, exp_line, cycles);
            end
            checks++;
            if (in_ready !== exp_rdy) begin
                errors++;
                // R2 handshake
                $display("FAIL R2 in_ready actual=%b expected=%b at cycle %0d", in_ready, exp_rdy, cycles);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_cfg(input logic [1:0] kind, input logic [3:0] plen, input logic sy,
                           input logic cm, input logic vs, input logic inv, input logic [3:0] len);
        @(negedge clk);
        cfg_pre_kind = kind;
        cfg_pre_len  = plen;
        cfg_sync_en  = sy;
        cfg_cmd_mode = cm;
        cfg_var_sync = vs;
        cfg_invert   = inv;
        cfg_char_len = len;
    endtask

    task automatic send(input logic [8:0] d, input logic c);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_cmd   = c;
        do @(negedge clk); while (!m_took);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_pending || m_active);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        half_tick = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        in_cmd = 1'b0;
        cfg_pre_kind = 2'd0;
        cfg_pre_len = 4'd8;
        cfg_sync_en = 1'b0;
        cfg_cmd_mode = 1'b0;
        cfg_var_sync = 1'b0;
        cfg_invert = 1'b0;
        cfg_char_len = 4'd8;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (tx_line !== 1'b1 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset actual=%b%b expected=11", tx_line, in_ready);
        end

        // R3 R5 R7 R11 basic character, all-ones preamble of 8
        send(9'h0A5, 1'b0);
        wait_idle();

        // R4 each preamble pattern, assorted lengths
        for (int k = 0; k < 4; k++) begin
            set_cfg(k[1:0], 4'(3 + 4 * k), 1'b0, 1'b0, 1'b0, 1'b0, 4'd8);
            send(9'(8'h3C + k), 1'b0);
            wait_idle();
        end

        // R3 zero and maximum preamble
        set_cfg(2'd2, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
        send(9'h055, 1'b0);
        wait_idle();
        set_cfg(2'd3, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6);
        send(9'h02A, 1'b1);
        wait_idle();

        // R8 R9 global sync kind, in_cmd opposite and ignored
        set_cfg(2'd0, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8);
        send(9'h0F0, 1'b0);
        wait_idle();
        set_cfg(2'd0, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8);
        send(9'h00F, 1'b1);
        wait_idle();

        // R10 per-character sync kind, global mode opposite and ignored
        set_cfg(2'd1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8);
        send(9'h081, 1'b1);
        wait_idle();
        set_cfg(2'd1, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd8);
        send(9'h018, 1'b0);
        wait_idle();

        // R6 inversion with one-bit marker and with sync
        set_cfg(2'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8);
        send(9'h0C3, 1'b0);
        wait_idle();
        set_cfg(2'd3, 4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9);
        send(9'h1B4, 1'b0);
        wait_idle();

        // R11 length limits and clamping
        set_cfg(2'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5);
        send(9'h1FF, 1'b0);
        wait_idle();
        set_cfg(2'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3);
        send(9'h1F5, 1'b0);
        wait_idle();
        set_cfg(2'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12);
        send(9'h16B, 1'b0);
        wait_idle();

        // R5 strobe every cycle and every fourth cycle
        tick_period = 1;
        set_cfg(2'd2, 4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8);
        send(9'h096, 1'b0);
        wait_idle();
        tick_period = 4;
        send(9'h069, 1'b0);
        wait_idle();
        tick_period = 3;

        // R12 configuration changes while a character is in flight
        force_tag = 12;
        set_cfg(2'd3, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9);
        send(9'h133, 1'b0);
        force_tag = 0;
        cfg_pre_kind = 2'd1;
        cfg_pre_len  = 4'd0;
        cfg_sync_en  = 1'b0;
        cfg_cmd_mode = 1'b0;
        cfg_invert   = 1'b1;
        cfg_char_len = 4'd5;
        in_data      = 9'h000;
        wait_idle();

        // R2 back-to-back characters with valid held
        set_cfg(2'd0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6);
        send(9'h015, 1'b0);
        send(9'h02A, 1'b0);
        wait_idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule